// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This controller turns a single internal data-memory access into one cycle on an asynchronous external parallel bus. The low address byte and the data byte share one 8-bit port (`ad_out`/`ad_oe` outbound, `ad_in` inbound). The high address byte has its own port. The controller produces an address-latch strobe (`ale`), an active-low write strobe (`wr_n`) and an active-low read strobe (`rd_n`). An external latch captures the low address on the falling edge of `ale`. The port then carries write data, or it is released so that the memory can drive read data.

The address space has two sectors, split at parameter `SECTOR_SPLIT`. Each sector has a 2-bit wait field, and the field of the addressed sector sets how many extra clocks the strobe phase is stretched. The CPU gives a one-bit hint that its next access is also to RAM; only then is an `ale` pulse issued in the closing period. With the bus-keeper enable set, the shared port keeps driving the last byte the controller put on it whenever the port is not carrying an access. With the enable clear, the port is released.

States and transitions:
- `XB_IDLE`: goes to `XB_ADDR` on `req_valid`.
- `XB_ADDR` (period T1): always goes to `XB_STRB`.
- `XB_STRB` (period T2): always goes to `XB_WAIT`.
- `XB_WAIT` (period T3, stretched): stays in `XB_WAIT` while the wait counter is non-zero, and goes to `XB_CLOSE` when it reaches zero.
- `XB_CLOSE` (the closing period): always goes to `XB_IDLE`.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset, `busy` is 0, `ale` is 0, `rd_n` and `wr_n` are 1, and `ad_oe` is 0.
- R2: In the first busy cycle (T1), `ale` is 1, `ad_oe` is 1, `ad_out` equals address bits 7:0, `addr_hi` equals address bits 15:8, and both strobes are high.
- R3: For a write (`req_we`=1), `wr_n` is low in every strobe cycle while `rd_n` stays high. In those cycles `ad_out` carries the write byte with `ad_oe`=1.
- R4: For a read, `rd_n` is low in every strobe cycle with `ad_oe`=0. `rdata` holds the `ad_in` value seen on the last strobe clock, and `rdata_valid` is 1 in the closing cycle.
- R5: With wait field value W (encoding 0b00..0b11 gives W=0..3), the strobe lasts 2+W cycles and `busy` lasts 4+W cycles.
- R6: Addresses at or above `SECTOR_SPLIT` (default 0x8000) take their wait field from `cfg_ws_hi`. Lower addresses take it from `cfg_ws_lo`. The field is sampled when the request is accepted.
- R7: In the closing cycle, `ale` is 1 exactly when `req_next_ram` was 1 at acceptance.
- R8: With `cfg_keep`=0, `ad_oe` is 0 in the closing cycle and in idle.
- R9: With `cfg_keep`=1, `ad_oe` is 1 in the closing cycle and in idle, and `ad_out` holds the last byte driven. For a read, that byte is the low address byte.
- R10: `rd_n` and `wr_n` are never low together, and `ale` is never high while a strobe is low.
- R11: `req_valid` while `busy`=1 is ignored: no new cycle starts and `addr_hi` keeps the current address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | CPU access request, accepted when idle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write byte |
| req_next_ram | input | 1 | Hint: next access is also to RAM |
| cfg_ws_lo | input | 2 | Wait field, lower sector |
| cfg_ws_hi | input | 2 | Wait field, upper sector |
| cfg_keep | input | 1 | Bus-keeper enable |
| busy | output | 1 | CPU must hold while set |
| rdata | output | 8 | Captured read byte |
| rdata_valid | output | 1 | Read byte valid (closing cycle) |
| ad_out | output | 8 | Shared address/data port, outbound value |
| ad_oe | output | 1 | Shared port output enable |
| ad_in | input | 8 | Shared port, inbound value |
| addr_hi | output | 8 | High address byte |
| ale | output | 1 | Address latch enable |
| wr_n | output | 1 | Write strobe, active low |
| rd_n | output | 1 | Read strobe, active low |

## Verification
The assertions assume that `req_valid` is acted on only from idle, and that the wait fields and `req_next_ram` matter only at the accepting edge. The bench therefore raises a request for exactly one clock while the block is idle. It changes the configuration only between accesses, except in the deliberate busy-time request that checks R11. Inputs change on the falling clock edge. The bench's memory model drives `ad_in` only while `rd_n` is low, so the captured byte depends on correct strobe timing.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    typedef enum logic [2:0] {
        XB_IDLE,
        XB_ADDR,
        XB_STRB,
        XB_WAIT,
        XB_CLOSE
    } xb_state_t;
    localparam int WS_W = 2;
endpackage

// File: rtl/xbus_sector_sel.sv
module xbus_sector_sel #(
    parameter int AW = 16,
    parameter int WSW = 2,
    parameter logic [AW-1:0] SPLIT = 16'h8000
) (
    input  logic [AW-1:0]  addr,
    input  logic [WSW-1:0] ws_hi,
    input  logic [WSW-1:0] ws_lo,
    output logic [WSW-1:0] ws_sel
);
    logic upper;
    assign upper  = (addr >= SPLIT);
    assign ws_sel = upper ? ws_hi : ws_lo;
endmodule

// File: rtl/xbus_wait_cnt.sv
module xbus_wait_cnt #(
    parameter int WSW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [WSW-1:0] init,
    input  logic           dec,
    output logic           zero
);
    logic [WSW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= init;
        else if (dec && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/xbus_keeper.sv
module xbus_keeper #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          drv_en,
    input  logic [DW-1:0] drv_val,
    input  logic          keep_en,
    input  logic          allow,
    output logic          oe,
    output logic [DW-1:0] val
);
    logic [DW-1:0] last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            last_q <= '0;
        else if (drv_en)
            last_q <= drv_val;
    end

    assign oe  = drv_en | (keep_en & allow);
    assign val = drv_en ? drv_val : last_q;
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter logic [AW-1:0] SECTOR_SPLIT = 16'h8000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_we,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    input  logic            req_next_ram,
    input  logic [WS_W-1:0] cfg_ws_lo,
    input  logic [WS_W-1:0] cfg_ws_hi,
    input  logic            cfg_keep,
    output logic            busy,
    output logic [DW-1:0]   rdata,
    output logic            rdata_valid,
    output logic [DW-1:0]   ad_out,
    output logic            ad_oe,
    input  logic [DW-1:0]   ad_in,
    output logic [AW-DW-1:0] addr_hi,
    output logic            ale,
    output logic            wr_n,
    output logic            rd_n
);
    localparam int HW = AW - DW;

    xb_state_t       state_q, state_d;
    logic [AW-1:0]   addr_q;
    logic [DW-1:0]   wdata_q;
    logic            we_q, hint_q;
    logic [WS_W-1:0] ws_q, ws_sel;
    logic            wait_zero, cnt_load, cnt_dec;
    logic            drv_en, keep_allow, accept;
    logic [DW-1:0]   drv_val;

    xbus_sector_sel #(.AW(AW), .WSW(WS_W), .SPLIT(SECTOR_SPLIT)) u_sector (
        .addr(req_addr), .ws_hi(cfg_ws_hi), .ws_lo(cfg_ws_lo), .ws_sel(ws_sel)
    );

    xbus_wait_cnt #(.WSW(WS_W)) u_wait (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .init(ws_q),
        .dec(cnt_dec), .zero(wait_zero)
    );

    xbus_keeper #(.DW(DW)) u_keep (
        .clk(clk), .rst_n(rst_n), .drv_en(drv_en), .drv_val(drv_val),
        .keep_en(cfg_keep), .allow(keep_allow), .oe(ad_oe), .val(ad_out)
    );

    assign accept = (state_q == XB_IDLE) && req_valid;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XB_IDLE:  if (req_valid) state_d = XB_ADDR;
            XB_ADDR:  state_d = XB_STRB;
            XB_STRB:  state_d = XB_WAIT;
            XB_WAIT:  if (wait_zero) state_d = XB_CLOSE;
            XB_CLOSE: state_d = XB_IDLE;
            default:  state_d = XB_IDLE;
        endcase
    end

    // state register and access capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= XB_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            we_q    <= 1'b0;
            hint_q  <= 1'b0;
            ws_q    <= '0;
            rdata   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                we_q    <= req_we;
                hint_q  <= req_next_ram;
                ws_q    <= ws_sel;
            end
            if (state_q == XB_WAIT && wait_zero && !we_q)
                rdata <= ad_in;
        end
    end

    // outputs
    always_comb begin
        ale         = 1'b0;
        wr_n        = 1'b1;
        rd_n        = 1'b1;
        drv_en      = 1'b0;
        drv_val     = wdata_q;
        keep_allow  = 1'b0;
        cnt_load    = 1'b0;
        cnt_dec     = 1'b0;
        rdata_valid = 1'b0;
        busy        = 1'b1;
        unique case (state_q)
            XB_IDLE: begin
                busy       = 1'b0;
                keep_allow = 1'b1;
            end
            XB_ADDR: begin
                ale     = 1'b1;
                drv_en  = 1'b1;
                drv_val = addr_q[DW-1:0];
            end
            XB_STRB: begin
                cnt_load = 1'b1;
                drv_en   = we_q;
                wr_n     = ~we_q;
                rd_n     = we_q;
            end
            XB_WAIT: begin
                cnt_dec = 1'b1;
                drv_en  = we_q;
                wr_n    = ~we_q;
                rd_n    = we_q;
            end
            XB_CLOSE: begin
                ale         = hint_q;
                keep_allow  = 1'b1;
                rdata_valid = ~we_q;
            end
            default: busy = 1'b0;
        endcase
    end

    assign addr_hi = addr_q[AW-1:DW];

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));
    // R10
    ale_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> !ale);
    // R4
    read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);
    // R2
    start_ale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> (ale && busy && rd_n && wr_n));
    // R5
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == XB_WAIT && !wait_zero) |=> (state_q == XB_WAIT));
    // R11
    req_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(addr_hi));
    // R9
    keep_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_keep && !busy && $past(!busy) && $past(cfg_keep)) |-> (ad_oe && $stable(ad_out)));
endmodule

// File: tb/xbus_ctrl_tb.sv
`timescale 1ns/1ps
module xbus_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_we = 1'b0, req_next_ram = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic [1:0] cfg_ws_lo = '0, cfg_ws_hi = '0;
    logic       cfg_keep = 1'b0;
    logic       busy, rdata_valid, ad_oe, ale, wr_n, rd_n;
    logic [7:0] rdata, ad_out, ad_in, addr_hi;
    logic [7:0] mem_byte = 8'h00;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    assign ad_in = rd_n ? 8'h00 : mem_byte;

    xbus_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_next_ram(req_next_ram),
        .cfg_ws_lo(cfg_ws_lo), .cfg_ws_hi(cfg_ws_hi), .cfg_keep(cfg_keep),
        .busy(busy), .rdata(rdata), .rdata_valid(rdata_valid), .ad_out(ad_out),
        .ad_oe(ad_oe), .ad_in(ad_in), .addr_hi(addr_hi), .ale(ale),
        .wr_n(wr_n), .rd_n(rd_n)
    );

    // observations of the last access
    logic t1_ale, t1_oe, t1_str;
    logic [7:0] t1_ad, t1_hi;
    int n_busy, n_strobe;
    bit data_ok, both_low;
    logic cl_ale, cl_oe, cl_rv;
    logic [7:0] cl_ad, cl_rd;
    logic id_oe, id_ale, id_busy;
    logic [7:0] id_ad, id_hi;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic run_access(input bit we, input logic [15:0] a, input logic [7:0] wd,
                              input bit hint, input bit poke);
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = wd; req_next_ram = hint;
        @(negedge clk);
        req_valid = 1'b0;
        t1_ale = ale; t1_oe = ad_oe; t1_ad = ad_out; t1_hi = addr_hi; t1_str = rd_n & wr_n;
        n_busy = 0; n_strobe = 0; data_ok = 1'b1; both_low = 1'b0;
        while (busy && n_busy < 40) begin
            n_busy++;
            if (!rd_n && !wr_n) both_low = 1'b1;
            if (!rd_n || !wr_n) begin
                n_strobe++;
                if (we && (wr_n || !rd_n || !ad_oe || ad_out != wd)) data_ok = 1'b0;
                if (!we && (rd_n || !wr_n || ad_oe)) data_ok = 1'b0;
            end
            cl_ale = ale; cl_oe = ad_oe; cl_ad = ad_out; cl_rv = rdata_valid; cl_rd = rdata;
            if (poke && n_busy == 3) begin
                req_valid = 1'b1; req_we = 1'b0; req_addr = 16'hFFFF;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        @(negedge clk);
        id_oe = ad_oe; id_ad = ad_out; id_ale = ale; id_busy = busy; id_hi = addr_hi;
    endtask

    task automatic t_reset();
        // R1
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(ale == 1'b0 && rd_n && wr_n, "R1 strobes", int'({ale, rd_n, wr_n}), 3);
        chk(ad_oe == 1'b0, "R1 ad_oe", int'(ad_oe), 0);
    endtask

    task automatic t_write_lo();
        cfg_keep = 1'b0; cfg_ws_lo = 2'b00; cfg_ws_hi = 2'b11;
        run_access(1'b1, 16'h1234, 8'hA5, 1'b0, 1'b0);
        chk(t1_ale && t1_oe && t1_str, "R2 T1 ale/oe/strobes", int'({t1_ale, t1_oe, t1_str}), 7);
        chk(t1_ad == 8'h34, "R2 T1 low address", int'(t1_ad), 'h34);
        chk(t1_hi == 8'h12, "R2 T1 high address", int'(t1_hi), 'h12);
        chk(data_ok, "R3 write strobe/data", int'(data_ok), 1);
        chk(n_strobe == 2, "R5 R6 strobe W=0 lower", n_strobe, 2);
        chk(n_busy == 4, "R5 busy W=0", n_busy, 4);
        chk(cl_ale == 1'b0, "R7 no closing ale", int'(cl_ale), 0);
        chk(cl_oe == 1'b0 && id_oe == 1'b0, "R8 port released", int'({cl_oe, id_oe}), 0);
        chk(!both_low, "R10 strobes exclusive", int'(both_low), 0);
    endtask

    task automatic t_read_hi();
        cfg_keep = 1'b0; cfg_ws_lo = 2'b00; cfg_ws_hi = 2'b11; mem_byte = 8'hC3;
        run_access(1'b0, 16'h9A56, 8'h00, 1'b1, 1'b0);
        chk(t1_ad == 8'h56 && t1_hi == 8'h9A, "R2 read T1 address", int'({t1_hi, t1_ad}), 'h9A56);
        chk(data_ok, "R4 read strobe with port released", int'(data_ok), 1);
        chk(n_strobe == 5, "R5 R6 strobe W=3 upper", n_strobe, 5);
        chk(n_busy == 7, "R5 busy W=3", n_busy, 7);
        chk(cl_rv && cl_rd == 8'hC3, "R4 read data", int'({cl_rv, cl_rd}), 'h1C3);
        chk(cl_ale == 1'b1, "R7 closing ale with hint", int'(cl_ale), 1);
    endtask

    task automatic t_sector_mix();
        cfg_ws_lo = 2'b10; cfg_ws_hi = 2'b01;
        run_access(1'b1, 16'hC000, 8'h3C, 1'b0, 1'b0);
        chk(n_strobe == 3 && data_ok, "R6 upper W=1 write", n_strobe, 3);
        mem_byte = 8'h81;
        run_access(1'b0, 16'h0100, 8'h00, 1'b0, 1'b0);
        chk(n_strobe == 4, "R6 lower W=2 read", n_strobe, 4);
        chk(n_busy == 6, "R5 busy W=2", n_busy, 6);
        chk(cl_rd == 8'h81 && cl_rv, "R4 read W=2", int'(cl_rd), 'h81);
        // boundary: 0x7FFF is lower, 0x8000 is upper
        cfg_ws_lo = 2'b00; cfg_ws_hi = 2'b11;
        run_access(1'b1, 16'h7FFF, 8'h11, 1'b0, 1'b0);
        chk(n_strobe == 2, "R6 boundary 0x7FFF lower", n_strobe, 2);
        run_access(1'b1, 16'h8000, 8'h22, 1'b0, 1'b0);
        chk(n_strobe == 5, "R6 boundary 0x8000 upper", n_strobe, 5);
    endtask

    task automatic t_keeper();
        cfg_keep = 1'b1; cfg_ws_lo = 2'b01;
        run_access(1'b1, 16'h0077, 8'h5E, 1'b0, 1'b0);
        chk(cl_oe && cl_ad == 8'h5E, "R9 keep write data in closing", int'({cl_oe, cl_ad}), 'h15E);
        chk(id_oe && id_ad == 8'h5E, "R9 keep write data in idle", int'({id_oe, id_ad}), 'h15E);
        mem_byte = 8'h44;
        cfg_ws_hi = 2'b00;
        run_access(1'b0, 16'h80AB, 8'h00, 1'b0, 1'b0);
        chk(data_ok, "R4 keeper off during read strobe", int'(data_ok), 1);
        chk(id_oe && id_ad == 8'hAB, "R9 keep low address after read", int'({id_oe, id_ad}), 'h1AB);
        cfg_keep = 1'b0;
        @(negedge clk);
        chk(ad_oe == 1'b0, "R8 release when keeper disabled", int'(ad_oe), 0);
    endtask

    task automatic t_ignore();
        cfg_ws_lo = 2'b01;
        run_access(1'b1, 16'h2345, 8'h66, 1'b0, 1'b1);
        chk(n_busy == 5, "R11 cycle length unchanged", n_busy, 5);
        chk(!id_busy && !id_ale, "R11 no new cycle", int'({id_busy, id_ale}), 0);
        chk(id_hi == 8'h23, "R11 high address kept", int'(id_hi), 'h23);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_lo();
        t_read_hi();
        t_sector_mix();
        t_keeper();
        t_ignore();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule